// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block drives a parallel RGB panel from a single pixel clock. From a set of programmable timing values it produces horizontal sync, vertical sync and data-enable, and it presents one colour word per clock. The frame is measured as one running count of pixel clocks. Vertical window edges are therefore absolute positions within the frame, not line numbers. A skew value shifts where each line begins relative to the start of the frame.

Inside the display window the block passes pixels from a ready/valid source. An optional smaller active window can be enabled on each axis. Display positions that fall outside it carry a fixed border colour. When the source fails to deliver a pixel, the block substitutes an underflow colour and keeps doing so. If recovery is enabled it returns to live pixels at the next frame. Otherwise it waits until the generator is stopped. A one-cycle pulse marks each frame start.

Software programs the timing while the generator is stopped. Writes made while it runs are held and applied together at the next frame boundary.

Top module: `panel_timing_gen`

## Requirements
- R1: After reset, hsync, vsync, data_en, frame_start, pix_ready and pix_out are all 0.
- R2: Register 1 holds the line period in [31:16] and the horizontal sync width in [15:0]; the raw horizontal sync is high while the line position is below the sync width.
- R3: Register 2 holds the frame period in pixel clocks and register 3 the vertical sync length in pixel clocks; the raw vertical sync is high while the frame count is below that length, and the frame count runs from 0 to frame period − 1.
- R4: data_en (raw) is high when the line position lies in [start, end] of register 4 (end [31:16], start [15:0]) and the frame count lies in [register 5, register 6] inclusive.
- R5: Register 12 [15:0] is the skew S; the line position equals (frame count − S) modulo the line period, so line position 0 occurs at frame count S.
- R6: Register 7 (enable bit 31, end [30:16], start [15:0]) and registers 8 (enable bit 31, start count) and 9 (end count) define the active window; an axis whose enable is clear uses the display window. Inside the display window but outside the active window pix_out is the border colour (register 10); inside the active window it is pix_data; with raw data-enable low it is 0.
- R7: Register 13 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data_en; while stopped each output rests at its inactive level.
- R8: Register 0 bit 0 starts (1) or stops (0) the generator; while stopped no frame_start is produced and pix_ready stays low.
- R9: frame_start is high for exactly one cycle when the frame count is 0, including the first frame after a start.
- R10: Writes made while running take effect only when the frame count wraps to 0.
- R11: pix_ready is high in the active window; a ready cycle with pix_valid low or pix_underflow high shows the underflow colour (register 11 [23:0]) and latches it for all later active pixels; with register 11 bit 31 set the latch clears at the next frame, otherwise only on stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register index |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Source has a pixel this cycle |
| pix_data | input | CW | Source pixel colour |
| pix_underflow | input | 1 | Source signals underflow |
| pix_ready | output | 1 | Pixel consumed this cycle |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| data_en | output | 1 | Data-enable after polarity |
| pix_out | output | CW | Colour driven to the panel |
| frame_start | output | 1 | One-cycle frame start pulse |

## Verification
On every cycle the assertions check several invariants. The frame count stays inside the programmed period, and frame_start never lasts two cycles. A stopped generator raises no frame start and no ready. Pixel colour is zero whenever data-enable is low, a non-recovering underflow latch stays set, and the latched timing never changes mid-frame. The exact positions of the sync edges, the display and active window boundaries, the skew offset, the polarity inversions, and whether a frame boundary applies a pending write or clears an underflow can only be shown by the bench. It does this by sampling fixed frame positions across several programmed configurations.

// File: rtl/panel_timing_gen.sv
module panel_timing_gen #(
  parameter int FW = 24,
  parameter int CW = 24,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_data,
  input  logic          pix_underflow,
  output logic          pix_ready,
  output logic          hsync,
  output logic          vsync,
  output logic          data_en,
  output logic [CW-1:0] pix_out,
  output logic          frame_start
);
  localparam int HW = 16;

  logic          unused_bits;
  assign unused_bits = ^cfg_wdata;

  // pending (software) copies
  logic          p_en, p_ahen, p_aven, p_rec;
  logic [HW-1:0] p_lp, p_hsw, p_dhs, p_dhe, p_ahs, p_skew;
  logic [HW-2:0] p_ahe;
  logic [FW-1:0] p_frame, p_vsw, p_dvs, p_dve, p_avs, p_ave;
  logic [CW-1:0] p_border, p_uflc;
  logic [2:0]    p_pol;

  // frame-latched copies
  logic          s_ahen, s_aven, s_rec;
  logic [HW-1:0] s_lp, s_hsw, s_dhs, s_dhe, s_ahs;
  logic [HW-2:0] s_ahe;
  logic [FW-1:0] s_frame, s_vsw, s_dvs, s_dve, s_avs, s_ave;
  logic [CW-1:0] s_border, s_uflc;
  logic [2:0]    s_pol;

  logic [FW-1:0] fcnt;
  logic [HW-1:0] hcnt, hinit;
  logic          wrap, load, hold;
  logic          h_disp, v_disp, h_act, v_act, de_c, act_c, ufl_evt;
  logic          hs_q, vs_q, de_q, fs_q;
  logic [CW-1:0] pix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_en <= 1'b0; p_ahen <= 1'b0; p_aven <= 1'b0; p_rec <= 1'b0;
      p_lp <= '0; p_hsw <= '0; p_dhs <= '0; p_dhe <= '0;
      p_ahs <= '0; p_ahe <= '0; p_skew <= '0;
      p_frame <= '0; p_vsw <= '0; p_dvs <= '0; p_dve <= '0;
      p_avs <= '0; p_ave <= '0;
      p_border <= '0; p_uflc <= '0; p_pol <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0):  p_en <= cfg_wdata[0];
        AW'(1):  begin p_lp <= cfg_wdata[31:16]; p_hsw <= cfg_wdata[15:0]; end
        AW'(2):  p_frame <= cfg_wdata[FW-1:0];
        AW'(3):  p_vsw <= cfg_wdata[FW-1:0];
        AW'(4):  begin p_dhe <= cfg_wdata[31:16]; p_dhs <= cfg_wdata[15:0]; end
        AW'(5):  p_dvs <= cfg_wdata[FW-1:0];
        AW'(6):  p_dve <= cfg_wdata[FW-1:0];
        AW'(7):  begin
                   p_ahen <= cfg_wdata[31];
                   p_ahe  <= cfg_wdata[30:16];
                   p_ahs  <= cfg_wdata[15:0];
                 end
        AW'(8):  begin p_aven <= cfg_wdata[31]; p_avs <= cfg_wdata[FW-1:0]; end
        AW'(9):  p_ave <= cfg_wdata[FW-1:0];
        AW'(10): p_border <= cfg_wdata[CW-1:0];
        AW'(11): begin p_rec <= cfg_wdata[31]; p_uflc <= cfg_wdata[CW-1:0]; end
        AW'(12): p_skew <= cfg_wdata[15:0];
        AW'(13): p_pol <= cfg_wdata[2:0];
        default: ;
      endcase
    end
  end

  assign wrap  = p_en && (fcnt == s_frame - FW'(1));
  assign load  = !p_en || wrap;
  assign hinit = (p_skew == '0) ? '0 : p_lp - p_skew;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ahen <= 1'b0; s_aven <= 1'b0; s_rec <= 1'b0;
      s_lp <= '0; s_hsw <= '0; s_dhs <= '0; s_dhe <= '0;
      s_ahs <= '0; s_ahe <= '0;
      s_frame <= '0; s_vsw <= '0; s_dvs <= '0; s_dve <= '0;
      s_avs <= '0; s_ave <= '0;
      s_border <= '0; s_uflc <= '0; s_pol <= '0;
    end else if (load) begin
      s_ahen <= p_ahen; s_aven <= p_aven; s_rec <= p_rec;
      s_lp <= p_lp; s_hsw <= p_hsw; s_dhs <= p_dhs; s_dhe <= p_dhe;
      s_ahs <= p_ahs; s_ahe <= p_ahe;
      s_frame <= p_frame; s_vsw <= p_vsw; s_dvs <= p_dvs; s_dve <= p_dve;
      s_avs <= p_avs; s_ave <= p_ave;
      s_border <= p_border; s_uflc <= p_uflc; s_pol <= p_pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      hcnt <= '0;
    end else if (load) begin
      fcnt <= '0;
      hcnt <= hinit;
    end else begin
      fcnt <= fcnt + FW'(1);
      hcnt <= (hcnt == s_lp - HW'(1)) ? '0 : hcnt + HW'(1);
    end
  end

  assign h_disp  = (hcnt >= s_dhs) && (hcnt <= s_dhe);
  assign v_disp  = (fcnt >= s_dvs) && (fcnt <= s_dve);
  assign h_act   = s_ahen ? ((hcnt >= s_ahs) && (hcnt <= {1'b0, s_ahe})) : h_disp;
  assign v_act   = s_aven ? ((fcnt >= s_avs) && (fcnt <= s_ave)) : v_disp;
  assign de_c    = p_en && h_disp && v_disp;
  assign act_c   = de_c && h_act && v_act;
  assign ufl_evt = act_c && (!pix_valid || pix_underflow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold <= 1'b0;
    else if (!p_en)            hold <= 1'b0;
    else if (wrap && s_rec)    hold <= 1'b0;
    else if (ufl_evt)          hold <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0; fs_q <= 1'b0;
      pix_q <= '0;
    end else begin
      hs_q <= (p_en && (hcnt < s_hsw)) ^ s_pol[0];
      vs_q <= (p_en && (fcnt < s_vsw)) ^ s_pol[1];
      de_q <= de_c;
      fs_q <= p_en && (fcnt == '0);
      if (!de_c)                pix_q <= '0;
      else if (!(h_act && v_act)) pix_q <= s_border;
      else if (hold || ufl_evt) pix_q <= s_uflc;
      else                      pix_q <= pix_data;
    end
  end

  logic de_pol;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) de_pol <= 1'b0;
    else        de_pol <= s_pol[2];
  end

  assign pix_ready   = act_c;
  assign hsync       = hs_q;
  assign vsync       = vs_q;
  assign data_en     = de_q ^ de_pol;
  assign pix_out     = pix_q;
  assign frame_start = fs_q;
endmodule

// File: rtl/panel_timing_gen_chk.sv
module panel_timing_gen_chk #(
  parameter int FW = 24,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          wrap,
  input logic [FW-1:0] fcnt,
  input logic [FW-1:0] frame_len,
  input logic          hold,
  input logic          rec,
  input logic          de_raw,
  input logic [CW-1:0] pix_out,
  input logic          pix_ready,
  input logic          frame_start
);
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_len > FW'(1)) |=> !frame_start); // R9
  AST_FCNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frame_len != '0) |-> (fcnt < frame_len)); // R3
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !de_raw |-> (pix_out == '0)); // R6
  AST_READY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> run); // R8
  AST_STOP_NO_FS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !frame_start); // R8
  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && run && !rec) |=> hold); // R11
  AST_MIDFRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(frame_len)); // R10
endmodule

bind panel_timing_gen panel_timing_gen_chk #(.FW(FW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(p_en), .wrap(wrap), .fcnt(fcnt),
  .frame_len(s_frame), .hold(hold), .rec(s_rec), .de_raw(de_q),
  .pix_out(pix_out), .pix_ready(pix_ready), .frame_start(frame_start)
);

// File: tb/panel_timing_gen_tb.sv
`timescale 1ns/1ps
module panel_timing_gen_tb_top;
  localparam int CW = 24;
  localparam logic [23:0] PIX = 24'h123456;
  localparam logic [23:0] BRD = 24'h00FF00;
  localparam logic [23:0] UFC = 24'h0000FF;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic pix_valid = 1'b1, pix_underflow = 1'b0;
  logic [CW-1:0] pix_data = PIX;
  logic pix_ready, hsync, vsync, data_en, frame_start;
  logic [CW-1:0] pix_out;

  int n_run = 0, n_fail = 0, cur = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  panel_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_underflow(pix_underflow), .pix_ready(pix_ready), .hsync(hsync),
    .vsync(vsync), .data_en(data_en), .pix_out(pix_out), .frame_start(frame_start)
  );

  // entry: {position[7:0], fs, hs, vs, de, kind[1:0]}  kind: 0 none, 1 border, 2 pixel
  localparam logic [13:0] TBL [16] = '{
    {8'd0,  1'b1,1'b1,1'b1,1'b0,2'd0}, {8'd1,  1'b0,1'b1,1'b1,1'b0,2'd0},
    {8'd2,  1'b0,1'b0,1'b1,1'b0,2'd0}, {8'd10, 1'b0,1'b1,1'b0,1'b0,2'd0},
    {8'd20, 1'b0,1'b1,1'b0,1'b0,2'd0}, {8'd23, 1'b0,1'b0,1'b0,1'b1,2'd1},
    {8'd24, 1'b0,1'b0,1'b0,1'b1,2'd1}, {8'd34, 1'b0,1'b0,1'b0,1'b1,2'd2},
    {8'd36, 1'b0,1'b0,1'b0,1'b1,2'd2}, {8'd37, 1'b0,1'b0,1'b0,1'b1,2'd1},
    {8'd38, 1'b0,1'b0,1'b0,1'b0,2'd0}, {8'd43, 1'b0,1'b0,1'b0,1'b1,2'd1},
    {8'd47, 1'b0,1'b0,1'b0,1'b1,2'd1}, {8'd53, 1'b0,1'b0,1'b0,1'b0,2'd0},
    {8'd59, 1'b0,1'b0,1'b0,1'b0,2'd0}, {8'd60, 1'b1,1'b1,1'b1,1'b0,2'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cur++;
    cfg_we = 1'b0;
  endtask

  task automatic go(input int p);
    while (cur < p) begin @(negedge clk); cur++; end
  endtask

  task automatic cfg_a(input logic [31:0] ufl);
    wr(1, {16'd10, 16'd2}); wr(2, 60); wr(3, 10);
    wr(4, {16'd7, 16'd3}); wr(5, 20); wr(6, 49);
    wr(7, 32'h8000_0000 | (32'd6 << 16) | 32'd4);
    wr(8, 32'h8000_0000 | 32'd30); wr(9, 39);
    wr(10, {8'd0, BRD}); wr(11, ufl); wr(12, 0); wr(13, 0);
  endtask

  task automatic start();
    wr(0, 1);
    for (int i = 0; i < 200 && !frame_start; i++) @(negedge clk);
    cur = 0;
  endtask

  task automatic stop();
    wr(0, 0);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] kind_pix(input logic [1:0] k);
    case (k)
      2'd1: return {8'd0, BRD};
      2'd2: return {8'd0, PIX};
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    int fs_seen;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 hsync", hsync, 0); check("R1 vsync", vsync, 0);
    check("R1 data_en", data_en, 0); check("R1 frame_start", frame_start, 0);
    check("R1 pix_out", pix_out, 0); check("R1 pix_ready", pix_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_a({8'd0, UFC});
    start();
    foreach (TBL[i]) begin
      go(int'(TBL[i][13:6]));
      check($sformatf("R9 fs @%0d", cur), frame_start, TBL[i][5]);
      check($sformatf("R2 hsync @%0d", cur), hsync, TBL[i][4]);
      check($sformatf("R3 vsync @%0d", cur), vsync, TBL[i][3]);
      check($sformatf("R4 data_en @%0d", cur), data_en, TBL[i][2]);
      check($sformatf("R6 pix @%0d", cur), pix_out, kind_pix(TBL[i][1:0]));
    end
    // R11: ready tracks the active window (counters one position ahead of outputs)
    go(93); check("R11 ready active", pix_ready, 1);
    go(96); check("R11 ready outside", pix_ready, 0);
    // R10: mid-frame write held until wrap
    go(100); wr(1, {16'd10, 16'd4});
    go(112); check("R10 hsync old width", hsync, 0);
    go(122); check("R10 hsync new width", hsync, 1);

    // R8: stop
    stop();
    fs_seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (frame_start || pix_ready) fs_seen++;
    end
    check("R8 no frame_start/ready while stopped", fs_seen, 0);
    check("R8 stopped hsync", hsync, 0);

    // R7: polarity
    cfg_a({8'd0, UFC});
    wr(13, 7);
    repeat (4) @(negedge clk);
    check("R7 idle hsync", hsync, 1); check("R7 idle vsync", vsync, 1);
    check("R7 idle data_en", data_en, 1);
    start();
    check("R7 hsync active low", hsync, 0); check("R7 vsync active low", vsync, 0);
    check("R7 data_en idle high", data_en, 1);
    go(23); check("R7 data_en active low", data_en, 0);
    stop();

    // R5 skew, R6 active window disabled
    cfg_a({8'd0, UFC});
    wr(12, 3); wr(5, 23); wr(6, 52); wr(7, 0); wr(8, 0);
    start();
    check("R5 hsync low at 0", hsync, 0);
    go(3);  check("R5 hsync at skew", hsync, 1);
    go(25); check("R5 data_en before start", data_en, 0);
    go(26); check("R5 data_en at start", data_en, 1);
    check("R6 disabled window pixel", pix_out, {8'd0, PIX});
    go(30); check("R6 disabled window end", pix_out, {8'd0, PIX});
    go(31); check("R5 data_en after end", data_en, 0);
    stop();

    // R11 underflow, no recovery
    cfg_a({8'd0, UFC});
    start();
    go(33); pix_underflow = 1'b1;
    go(34); pix_underflow = 1'b0;
    check("R11 underflow colour", pix_out, {8'd0, UFC});
    go(36); check("R11 underflow latched", pix_out, {8'd0, UFC});
    go(84); check("R11 border unaffected", pix_out, {8'd0, BRD});
    go(94); check("R11 no recovery next frame", pix_out, {8'd0, UFC});
    stop();

    // R11 underflow with recovery (bit 31)
    cfg_a(32'h8000_0000 | {8'd0, UFC});
    start();
    go(33); pix_valid = 1'b0;
    go(34); pix_valid = 1'b1;
    check("R11 invalid gives underflow colour", pix_out, {8'd0, UFC});
    go(94); check("R11 recovery next frame", pix_out, {8'd0, PIX});
    stop();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule